// File: doc/BRIEF.md
# Indirect Control and Status Register Unit for an Ethernet Controller

This block is the host-facing register file of a bus-mastering Ethernet controller. The host sees only two 16-bit ports. A write to the index port chooses one control/status register. Later accesses on the data port then read or write that register. The index is held between accesses, so a driver can poll or update one register many times without writing the index again.

Register 0 holds the run control, the event flags and the interrupt enable. Each of its fields follows its own write rule:

- Command bits are set by writing 1.
- Event flags are cleared by writing 1.
- Summary bits are read-only.

Registers 1 and 2 hold the two halves of the initialisation-block address. Register 3 holds three bus and byte-order control bits. Registers 8 to 11 hold a 64-bit multicast filter. Register 15 holds the mode word, whose top bit enables promiscuous reception.

The transmit and receive engines report events on a 7-bit pulse bus. The block returns to them one-cycle init, start, stop and poll strobes and a level interrupt.

Run control is a three-state machine:

| State | Entered from | Condition |
|---|---|---|
| `ST_HALTED` | reset, or any state | halt command written |
| `ST_LOADING` | `ST_HALTED` or `ST_ACTIVE` | init command written without start |
| `ST_ACTIVE` | `ST_HALTED` or `ST_LOADING` | start command written |

If one write carries both start and init, `ST_ACTIVE` is taken and both strobes fire. A write that carries halt always goes to `ST_HALTED`, whatever else it carries.

Top module: `nic_csr_unit`

## Requirements
- R1: After reset the index is 0, register 0 reads 0x0004 (halted), `irq` is 0 and every configuration register and output is 0.
- R2: The index written on the index port is kept until it is written again, so repeated data-port accesses reach the same register. Indices 4 to 7 and 12 to 14 read 0.
- R3: Writing 1 to register 0 bit 0 (init) or bit 1 (start) gives a one-cycle `init_pulse` or `start_pulse` in the cycle after the write. Writing 1 to bit 3 (poll) gives a `poll_pulse` in that cycle only if the next state is `ST_ACTIVE`. Each of these bits reads 1 only during its strobe cycle, and writing 0 to them does nothing.
- R4: Writing 1 to bit 2 (halt) enters `ST_HALTED` and gives a `stop_pulse`. The same write clears all event flags and the interrupt enable, and it suppresses init, start and poll even when they are written in that same word. Register 0 then reads exactly 0x0004, and bit 2 stays set until init or start is written.
- R5: Bit 4 (transmitter on) and bit 5 (receiver on) read 1 only in `ST_ACTIVE`.
- R6: Event input k (k = 0..6) sets register 0 bit 8+k on the next edge. The flags are, in order: init done, tx done, rx done, memory error, missed frame, heartbeat error, babble. Events are ignored in `ST_HALTED`.
- R7: Writing 1 to a flag bit clears it, and writing 0 to it leaves it unchanged. An event arriving in the same cycle as its clear wins.
- R8: Bit 15 reads the OR of bits 11 to 14, and bit 7 reads the OR of bits 8 to 14. Bits 4, 5, 7 and 15 ignore writes.
- R9: Bit 6 (interrupt enable) is read/write, and `irq` equals bit 7 AND bit 6.
- R10: Registers 1, 2, 3 (3 bits), 8 to 11 and 15 accept writes only in `ST_HALTED`. Their contents drive the following outputs:
  - `init_addr` = {reg2, reg1}
  - `bus_ctl`
  - `mcast_filter`, with reg 8+w on bits 16w+15:16w
  - `promisc` = reg15 bit 15
- R11: A halt write clears register 3, which returns the byte-swap bit (bit 2) and the other bus-control bits to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_we | input | 1 | Write strobe for the index port |
| data_we | input | 1 | Write strobe for the data port |
| wdata | input | 16 | Write data, shared by both ports |
| rdata | output | 16 | Read data of the indexed register |
| ev_pulse | input | 7 | Engine event pulses; bit k sets register 0 bit 8+k |
| irq | output | 1 | Level interrupt |
| init_pulse | output | 1 | One-cycle strobe to fetch the init block |
| start_pulse | output | 1 | One-cycle start strobe |
| stop_pulse | output | 1 | One-cycle stop strobe |
| poll_pulse | output | 1 | One-cycle transmit poll strobe |
| init_addr | output | 32 | Init-block address |
| bus_ctl | output | 3 | Bus and byte-order control bits |
| mcast_filter | output | 64 | Multicast filter |
| promisc | output | 1 | Promiscuous reception enable |

## Verification
The assertions check four relations on every cycle:

- A halt write always reads back as 0x0004 and never coincides with another strobe.
- The on bits never appear while halted.
- No event flag survives in `ST_HALTED`.
- `irq` never rises without both the summary and the enable bits, and configuration outputs never move outside `ST_HALTED`.

Only the bench scenarios can show the rest. That includes the exact bit position of each event flag, the read-back of every index, and write-1-to-clear against a simultaneous event. It also covers the poll strobe being dropped while halted and the presence probe's INIT-plus-halt write.

// File: rtl/nic_csr_pkg.sv
package nic_csr_pkg;

    typedef enum logic [1:0] {
        ST_HALTED  = 2'd0,
        ST_LOADING = 2'd1,
        ST_ACTIVE  = 2'd2
    } run_state_e;

    // Register 0 bit positions
    localparam int B_INIT  = 0;
    localparam int B_START = 1;
    localparam int B_HALT  = 2;
    localparam int B_POLL  = 3;
    localparam int B_TXON  = 4;
    localparam int B_RXON  = 5;
    localparam int B_IEN   = 6;
    localparam int B_IRQ   = 7;
    localparam int B_FLAG0 = 8;
    localparam int B_ERR   = 15;

    localparam int NUM_FLAGS   = 7;
    localparam int ERR_FLAG_LO = 3;   // flags 3..6 feed the error summary

    // Register indices
    localparam int IDX_CTRL   = 0;
    localparam int IDX_IBA_LO = 1;
    localparam int IDX_IBA_HI = 2;
    localparam int IDX_BUS    = 3;
    localparam int IDX_MCAST0 = 8;
    localparam int IDX_MODE   = 15;

endpackage

// File: rtl/nic_csr_fsm.sv
module nic_csr_fsm
    import nic_csr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_we,
    input  logic       cmd_init,
    input  logic       cmd_start,
    input  logic       cmd_halt,
    input  logic       cmd_poll,
    output run_state_e state_q,
    output logic       init_pulse,
    output logic       start_pulse,
    output logic       stop_pulse,
    output logic       poll_pulse
);

    run_state_e state_n;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_HALTED: begin
                if (ctrl_we && !cmd_halt) begin
                    if (cmd_start)     state_n = ST_ACTIVE;
                    else if (cmd_init) state_n = ST_LOADING;
                end
            end
            ST_LOADING: begin
                if (ctrl_we) begin
                    if (cmd_halt)       state_n = ST_HALTED;
                    else if (cmd_start) state_n = ST_ACTIVE;
                end
            end
            ST_ACTIVE: begin
                if (ctrl_we) begin
                    if (cmd_halt)      state_n = ST_HALTED;
                    else if (cmd_start) state_n = ST_ACTIVE;
                    else if (cmd_init)  state_n = ST_LOADING;
                end
            end
            default: state_n = ST_HALTED;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HALTED;
        else        state_q <= state_n;
    end

    // Strobe outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_pulse  <= 1'b0;
            start_pulse <= 1'b0;
            stop_pulse  <= 1'b0;
            poll_pulse  <= 1'b0;
        end else begin
            init_pulse  <= ctrl_we && cmd_init  && !cmd_halt;
            start_pulse <= ctrl_we && cmd_start && !cmd_halt;
            stop_pulse  <= ctrl_we && cmd_halt;
            poll_pulse  <= ctrl_we && cmd_poll  && !cmd_halt
                           && (state_n == ST_ACTIVE);
        end
    end

endmodule

// File: rtl/nic_csr_flags.sv
module nic_csr_flags #(
    parameter int NF = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          clear_all,
    input  logic [NF-1:0] ev,
    input  logic [NF-1:0] w1c,
    input  logic          ien_we,
    input  logic          ien_d,
    output logic [NF-1:0] flags_q,
    output logic          ien_q
);

    for (genvar k = 0; k < NF; k++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n || clear_all)
                flags_q[k] <= 1'b0;
            else if (accept && ev[k])
                flags_q[k] <= 1'b1;
            else if (w1c[k])
                flags_q[k] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear_all) ien_q <= 1'b0;
        else if (ien_we)         ien_q <= ien_d;
    end

endmodule

// File: rtl/nic_csr_cfg.sv
module nic_csr_cfg #(
    parameter int DW       = 16,
    parameter int IDX_W    = 4,
    parameter int MC_WORDS = 4,
    parameter int BUS_BITS = 3,
    parameter int LO_IDX   = 1,
    parameter int HI_IDX   = 2,
    parameter int BUS_IDX  = 3,
    parameter int MC_IDX0  = 8,
    parameter int MODE_IDX = 15
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [IDX_W-1:0]       idx,
    input  logic [DW-1:0]          wd,
    input  logic                   bus_clr,
    output logic [DW-1:0]          iba_lo,
    output logic [DW-1:0]          iba_hi,
    output logic [BUS_BITS-1:0]    bus_q,
    output logic [MC_WORDS*DW-1:0] mc_q,
    output logic [DW-1:0]          mode_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iba_lo <= '0;
            iba_hi <= '0;
            mode_q <= '0;
        end else if (we) begin
            if (idx == IDX_W'(LO_IDX))   iba_lo <= wd;
            if (idx == IDX_W'(HI_IDX))   iba_hi <= wd;
            if (idx == IDX_W'(MODE_IDX)) mode_q <= wd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || bus_clr)
            bus_q <= '0;
        else if (we && idx == IDX_W'(BUS_IDX))
            bus_q <= wd[BUS_BITS-1:0];
    end

    for (genvar w = 0; w < MC_WORDS; w++) begin : g_mc
        always_ff @(posedge clk) begin
            if (!rst_n)
                mc_q[w*DW +: DW] <= '0;
            else if (we && idx == IDX_W'(MC_IDX0 + w))
                mc_q[w*DW +: DW] <= wd;
        end
    end

endmodule

// File: rtl/nic_csr_unit.sv
module nic_csr_unit
    import nic_csr_pkg::*;
#(
    parameter int IDX_W    = 4,
    parameter int MC_WORDS = 4,
    parameter int BUS_BITS = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   idx_we,
    input  logic                   data_we,
    input  logic [15:0]            wdata,
    output logic [15:0]            rdata,
    input  logic [NUM_FLAGS-1:0]   ev_pulse,
    output logic                   irq,
    output logic                   init_pulse,
    output logic                   start_pulse,
    output logic                   stop_pulse,
    output logic                   poll_pulse,
    output logic [31:0]            init_addr,
    output logic [BUS_BITS-1:0]    bus_ctl,
    output logic [MC_WORDS*16-1:0] mcast_filter,
    output logic                   promisc
);

    localparam int DW   = 16;
    localparam int MC_W = MC_WORDS * DW;

    logic [IDX_W-1:0]     idx_q;
    run_state_e           state_q;
    logic [NUM_FLAGS-1:0] flags_q;
    logic                 ien_q;
    logic                 ctrl_we;
    logic                 halt_wr;
    logic                 halted;
    logic [DW-1:0]        csr0_rd;
    logic [DW-1:0]        iba_lo, iba_hi, mode_q;
    logic [MC_W-1:0]      mc_q;
    logic [BUS_BITS-1:0]  bus_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      idx_q <= '0;
        else if (idx_we) idx_q <= wdata[IDX_W-1:0];
    end

    assign ctrl_we = data_we && (idx_q == IDX_W'(IDX_CTRL));
    assign halt_wr = ctrl_we && wdata[B_HALT];
    assign halted  = (state_q == ST_HALTED);

    nic_csr_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (ctrl_we),
        .cmd_init   (wdata[B_INIT]),
        .cmd_start  (wdata[B_START]),
        .cmd_halt   (wdata[B_HALT]),
        .cmd_poll   (wdata[B_POLL]),
        .state_q    (state_q),
        .init_pulse (init_pulse),
        .start_pulse(start_pulse),
        .stop_pulse (stop_pulse),
        .poll_pulse (poll_pulse)
    );

    nic_csr_flags #(.NF(NUM_FLAGS)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (!halted),
        .clear_all(halt_wr),
        .ev       (ev_pulse),
        .w1c      (ctrl_we ? wdata[B_FLAG0 +: NUM_FLAGS] : '0),
        .ien_we   (ctrl_we),
        .ien_d    (wdata[B_IEN]),
        .flags_q  (flags_q),
        .ien_q    (ien_q)
    );

    nic_csr_cfg #(
        .DW      (DW),
        .IDX_W   (IDX_W),
        .MC_WORDS(MC_WORDS),
        .BUS_BITS(BUS_BITS),
        .LO_IDX  (IDX_IBA_LO),
        .HI_IDX  (IDX_IBA_HI),
        .BUS_IDX (IDX_BUS),
        .MC_IDX0 (IDX_MCAST0),
        .MODE_IDX(IDX_MODE)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (data_we && halted),
        .idx    (idx_q),
        .wd     (wdata),
        .bus_clr(halt_wr),
        .iba_lo (iba_lo),
        .iba_hi (iba_hi),
        .bus_q  (bus_q),
        .mc_q   (mc_q),
        .mode_q (mode_q)
    );

    always_comb begin
        csr0_rd          = '0;
        csr0_rd[B_INIT]  = init_pulse;
        csr0_rd[B_START] = start_pulse;
        csr0_rd[B_HALT]  = halted;
        csr0_rd[B_POLL]  = poll_pulse;
        csr0_rd[B_TXON]  = (state_q == ST_ACTIVE);
        csr0_rd[B_RXON]  = (state_q == ST_ACTIVE);
        csr0_rd[B_IEN]   = ien_q;
        csr0_rd[B_IRQ]   = |flags_q;
        csr0_rd[B_FLAG0 +: NUM_FLAGS] = flags_q;
        csr0_rd[B_ERR]   = |flags_q[NUM_FLAGS-1:ERR_FLAG_LO];
    end

    always_comb begin
        rdata = '0;
        if (idx_q == IDX_W'(IDX_CTRL))   rdata = csr0_rd;
        if (idx_q == IDX_W'(IDX_IBA_LO)) rdata = iba_lo;
        if (idx_q == IDX_W'(IDX_IBA_HI)) rdata = iba_hi;
        if (idx_q == IDX_W'(IDX_BUS))    rdata = DW'(bus_q);
        if (idx_q == IDX_W'(IDX_MODE))   rdata = mode_q;
        for (int w = 0; w < MC_WORDS; w++)
            if (idx_q == IDX_W'(IDX_MCAST0 + w)) rdata = mc_q[w*DW +: DW];
    end

    assign irq          = ien_q && (|flags_q);
    assign init_addr    = {iba_hi, iba_lo};
    assign bus_ctl      = bus_q;
    assign mcast_filter = mc_q;
    assign promisc      = mode_q[DW-1];

endmodule

// File: rtl/nic_csr_checker.sv
module nic_csr_checker #(
    parameter int IDX_W    = 4,
    parameter int BUS_BITS = 3,
    parameter int MC_W     = 64
) (
    input logic                clk,
    input logic                rst_n,
    input logic                data_we,
    input logic [IDX_W-1:0]    idx_q,
    input logic [15:0]         wdata,
    input logic [15:0]         csr0_rd,
    input logic                irq,
    input logic                init_pulse,
    input logic                start_pulse,
    input logic                stop_pulse,
    input logic                poll_pulse,
    input logic [31:0]         init_addr,
    input logic [BUS_BITS-1:0] bus_ctl,
    input logic [MC_W-1:0]     mcast_filter,
    input logic                promisc
);

    logic halt_wr;
    assign halt_wr = data_we && (idx_q == '0) && wdata[2];

    // R4: a halt write reads back as the bare halt bit
    a_r4_stop_probe: assert property (@(posedge clk) disable iff (!rst_n)
        halt_wr |=> (csr0_rd == 16'h0004));

    // R4: the stop strobe never shares a cycle with another strobe
    a_r4_stop_excl: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |-> !(init_pulse || start_pulse || poll_pulse));

    // R5: the on bits never coexist with the halt bit
    a_r5_txon_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        (csr0_rd[4] || csr0_rd[5]) |-> !csr0_rd[2]);

    // R6: no event flag is present while halted
    a_r6_no_flags_halted: assert property (@(posedge clk) disable iff (!rst_n)
        csr0_rd[2] |-> (csr0_rd[14:8] == 7'd0));

    // R9: the interrupt needs both summary and enable
    a_r9_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (csr0_rd[7] && csr0_rd[6]));

    // R10: configuration does not move outside the halted state
    a_r10_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (!csr0_rd[2] && !halt_wr) |=>
            ($stable(init_addr) && $stable(bus_ctl) &&
             $stable(mcast_filter) && $stable(promisc)));

endmodule

bind nic_csr_unit nic_csr_checker #(
    .IDX_W   (IDX_W),
    .BUS_BITS(BUS_BITS),
    .MC_W    (MC_WORDS*16)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .data_we     (data_we),
    .idx_q       (idx_q),
    .wdata       (wdata),
    .csr0_rd     (csr0_rd),
    .irq         (irq),
    .init_pulse  (init_pulse),
    .start_pulse (start_pulse),
    .stop_pulse  (stop_pulse),
    .poll_pulse  (poll_pulse),
    .init_addr   (init_addr),
    .bus_ctl     (bus_ctl),
    .mcast_filter(mcast_filter),
    .promisc     (promisc)
);

// File: tb/sim_nic_csr_unit.sv
module sim_nic_csr_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        idx_we = 1'b0;
    logic        data_we = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [6:0]  ev_pulse = '0;
    logic        irq, init_pulse, start_pulse, stop_pulse, poll_pulse;
    logic [31:0] init_addr;
    logic [2:0]  bus_ctl;
    logic [63:0] mcast_filter;
    logic        promisc;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;   // 250 MHz

    nic_csr_unit u0 (
        .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .data_we(data_we),
        .wdata(wdata), .rdata(rdata), .ev_pulse(ev_pulse), .irq(irq),
        .init_pulse(init_pulse), .start_pulse(start_pulse),
        .stop_pulse(stop_pulse), .poll_pulse(poll_pulse),
        .init_addr(init_addr), .bus_ctl(bus_ctl),
        .mcast_filter(mcast_filter), .promisc(promisc)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_idx(input int i);
        idx_we = 1'b1; wdata = 16'(i);
        step();
        idx_we = 1'b0;
    endtask

    task automatic wr(input logic [15:0] v);
        data_we = 1'b1; wdata = v;
        step();
        data_we = 1'b0;
    endtask

    task automatic fire(input int k);
        ev_pulse = 7'(1 << k);
        step();
        ev_pulse = '0;
    endtask

    function automatic logic [15:0] pat(input int i);
        return 16'hA5C3 ^ (16'(i) * 16'h1111);
    endfunction

    function automatic bit is_cfg(input int i);
        return (i >= 1 && i <= 3) || (i >= 8 && i <= 11) || i == 15;
    endfunction

    function automatic logic [15:0] cfg_exp(input int i);
        if (!is_cfg(i)) return 16'h0;
        if (i == 3)     return pat(i) & 16'h0007;
        return pat(i);
    endfunction

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state, R2 unimplemented indices
        check("R1 ctrl reset", rdata, 16'h0004);
        check("R1 irq reset", irq, 0);
        check("R1 cfg outputs", {init_addr, mcast_filter, bus_ctl, promisc}, 0);
        for (int i = 0; i < 16; i++) begin
            set_idx(i);
            check("R2 reset read", rdata, (i == 0) ? 16'h0004 : 16'h0);
        end

        // R10 config writes while halted, R2 index retention
        for (int i = 1; i < 16; i++) begin
            set_idx(i);
            wr(pat(i));
            check("R10 readback", rdata, cfg_exp(i));
            step();
            check("R2 repeat read", rdata, cfg_exp(i));
        end
        check("R10 init_addr", init_addr, {pat(2), pat(1)});
        check("R10 mcast", mcast_filter, {pat(11), pat(10), pat(9), pat(8)});
        check("R10 promisc", promisc, pat(15)[15]);
        check("R10 bus_ctl", bus_ctl, pat(3)[2:0]);

        // R4 probe write: init plus halt, R11 bus control cleared
        set_idx(0);
        wr(16'h0005);
        check("R4 probe read", rdata, 16'h0004);
        check("R4 stop strobe", {stop_pulse, init_pulse}, 2'b10);
        check("R11 bus cleared", bus_ctl, 0);
        set_idx(3);
        wr(16'h0004);
        check("R11 swap set", bus_ctl, 3'b100);
        set_idx(0);

        // R6 events ignored while halted
        for (int k = 0; k < 7; k++) begin
            fire(k);
            check("R6 ignored halted", {irq, rdata}, {1'b0, 16'h0004});
        end
        // R3 poll dropped while halted, zero writes have no effect
        wr(16'h0008);
        check("R3 poll halted", {poll_pulse, rdata}, {1'b0, 16'h0004});
        wr(16'h0000);
        check("R4 halt persists", rdata, 16'h0004);

        // R3 init strobe, R5 loading state
        wr(16'h0001);
        check("R3 init strobe", {init_pulse, start_pulse, stop_pulse}, 3'b100);
        check("R3 init bit read", rdata, 16'h0001);
        step();
        check("R3 init self-clear", {init_pulse, rdata}, 17'h0);
        // R10 locked outside halted
        set_idx(1);
        wr(16'hFFFF);
        check("R10 locked", rdata, pat(1));
        set_idx(0);

        // R6 init done, R9 enable gating
        fire(0);
        check("R6 idon", {irq, rdata}, {1'b0, 16'h0180});
        wr(16'h0040);
        check("R9 irq on", {irq, rdata}, {1'b1, 16'h01C0});
        wr(16'h0142);
        check("R3 start strobe", start_pulse, 1);
        check("R5 start read", {irq, rdata}, {1'b0, 16'h0072});
        step();
        check("R5 active", rdata, 16'h0070);

        // R6 R7 R8 event sweep
        for (int k = 0; k < 7; k++) begin
            logic [15:0] e;
            fire(k);
            e = 16'h00F0 | 16'(1 << (8 + k)) | ((k >= 3) ? 16'h8000 : 16'h0);
            check("R6 flag set", rdata, e);
            check("R9 irq level", irq, 1);
            wr(16'h0040);
            check("R7 zero keeps", rdata, e);
            wr(16'h0040 | 16'(1 << (8 + k)));
            check("R7 w1c clears", {irq, rdata}, {1'b0, 16'h0070});
        end

        // R8 read-only bits ignore writes
        wr(16'h80F0);
        check("R8 read-only", rdata, 16'h0070);
        wr(16'h0000);
        check("R9 ien off", rdata, 16'h0030);
        wr(16'h0040);

        // R7 event beats simultaneous clear
        fire(1);
        ev_pulse = 7'b0000010;
        wr(16'h0240);
        ev_pulse = '0;
        check("R7 event wins", rdata, 16'h02F0);
        wr(16'h0240);

        // R3 poll while active
        wr(16'h0048);
        check("R3 poll strobe", {poll_pulse, rdata}, {1'b1, 16'h0078});
        step();
        check("R3 poll clear", {poll_pulse, rdata}, {1'b0, 16'h0070});

        // R4 halt while active with flags, R11
        fire(4);
        check("R11 swap kept", bus_ctl, 3'b100);
        wr(16'h0004);
        check("R4 halt clears", {irq, stop_pulse, rdata}, {2'b01, 16'h0004});
        check("R11 swap cleared", bus_ctl, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

endmodule